// File: doc/BRIEF.md
# Decimal-Correcting Byte ALU

This block is the arithmetic-logic unit of a small microcoded calculator core whose data memory is addressed in nibbles and whose numbers are held as BCD digits. Each clock it takes two 8-bit operands, a 4-bit operation code and the incoming carry and half-carry flags. One cycle later it presents an 8-bit result with carry, half-carry and zero flags. The microcode feeds the flags back as needed.

Fourteen operations are decoded: binary add and subtract with and without carry, increment and decrement, four bitwise and move operations, a nibble exchange, and three decimal corrections. The packed correction turns the binary sum of two packed BCD bytes into a packed BCD byte and a decimal carry. The two unpacked corrections fix a single BCD digit after a binary add or subtract and report the digit carry or borrow. Multi-digit decimal arithmetic is built by chaining a binary add with carry and a correction, digit pair by digit pair. Operand A is the one corrected.

Top module: `bcd_alu`

## Requirements
- R1: While rst_ni is low, res_o is 0x00, c_o and h_o are 0 and z_o is 1.
- R2: Outputs are registered: the result of the inputs present at a rising clock edge appears after that edge and holds until the next edge.
- R3: Code 0 gives a_i+b_i and code 1 gives a_i+b_i+c_i, modulo 256. c_o is the carry out of bit 7 and h_o the carry out of bit 3.
- R4: Code 2 gives a_i-b_i and code 3 gives a_i-b_i-c_i, modulo 256. c_o is 1 when a borrow leaves bit 7 and h_o is 1 when bit 4 borrows from the low nibble.
- R5: Code 8 gives a_i+1 and code 9 gives a_i-1, modulo 256. The flags follow R3 and R4 respectively with b_i taken as 1.
- R6: Codes 4, 5, 6 and 7 give a_i AND b_i, a_i OR b_i, a_i XOR b_i and b_i. c_o and h_o are cleared.
- R7: Code 10 returns a_i with its two nibbles exchanged and clears c_o and h_o.
- R8: Code 11 is the packed correction of a_i. Let L be (low nibble > 9) or h_i. Add 6 when L holds, giving t. Let U be (high nibble of t > 9) or c_i or a carry out of bit 7 in that add. Add 0x60 to t when U holds. c_o is U and h_o is L.
- R9: Code 12 is the unpacked correction after an add. Let L be (low nibble of a_i > 9) or h_i. The result is the low nibble plus 6 when L holds, or the low nibble alone when it does not, kept to 4 bits, with the upper nibble zero. c_o and h_o both equal L.
- R10: Code 13 is the unpacked correction after a subtract. It is the same as R9 except that 6 is subtracted modulo 16.
- R11: z_o is 1 exactly when the 8-bit result is zero, for every code.
- R12: Codes 14 and 15 give result 0x00 with c_o and h_o cleared, so z_o is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation code |
| a_i | input | 8 | Operand A (corrected operand for codes 11 to 13) |
| b_i | input | 8 | Operand B |
| c_i | input | 1 | Incoming carry flag |
| h_i | input | 1 | Incoming half-carry flag |
| res_o | output | 8 | Registered result |
| c_o | output | 1 | Registered carry or borrow flag |
| h_o | output | 1 | Registered half-carry flag |
| z_o | output | 1 | Registered zero flag |

## Verification
Assertions check on every cycle the things that follow directly from the previous cycle's inputs. These are the 9-bit sum of an add, the carry and half-carry cleared after logic and exchange codes, and the zero upper nibble and equal flags of the unpacked corrections. They also check that a set incoming carry forces a packed-correction carry, and that unused codes return zero. The exact digit arithmetic of the packed correction cannot be seen by any single property. This covers the 0xFA-style overflow of the low adjust, borrow and half-borrow on subtract with carry, and the zero flag across all codes. The bench's directed corner vectors and its long pseudo-random sweep show these, with every cycle compared against a behavioural model.

// File: rtl/bcd_alu_pkg.sv
package bcd_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBC  = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_PASS = 4'd7,
    OP_INC  = 4'd8,
    OP_DEC  = 4'd9,
    OP_SWAP = 4'd10,
    OP_DPK  = 4'd11,
    OP_DUA  = 4'd12,
    OP_DUS  = 4'd13
  } alu_op_e;
endpackage

// File: rtl/bcd_alu_arith.sv
module bcd_alu_arith #(
  parameter int DW = 8,
  parameter int HB = 4
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          cin_i,
  input  logic          sub_i,
  output logic [DW-1:0] sum_o,
  output logic          c_o,
  output logic          h_o
);
  logic [DW:0] wide;
  logic [HB:0] low;

  always_comb begin
    if (sub_i) begin
      wide = {1'b0, a_i} - {1'b0, b_i} - {{DW{1'b0}}, cin_i};
      low  = {1'b0, a_i[HB-1:0]} - {1'b0, b_i[HB-1:0]} - {{HB{1'b0}}, cin_i};
    end else begin
      wide = {1'b0, a_i} + {1'b0, b_i} + {{DW{1'b0}}, cin_i};
      low  = {1'b0, a_i[HB-1:0]} + {1'b0, b_i[HB-1:0]} + {{HB{1'b0}}, cin_i};
    end
  end

  assign sum_o = wide[DW-1:0];
  assign c_o   = wide[DW];
  assign h_o   = low[HB];
endmodule

// File: rtl/bcd_alu_logic.sv
module bcd_alu_logic
  import bcd_alu_pkg::*;
#(
  parameter int DW = 8,
  parameter int NW = 4
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [3:0]    op_i,
  output logic [DW-1:0] res_o
);
  localparam int NN = DW / NW;

  logic [DW-1:0] swapped;

  // nibble order reversed; with two nibbles this is an exchange
  for (genvar g = 0; g < NN; g++) begin : g_nib
    assign swapped[g*NW +: NW] = a_i[(NN-1-g)*NW +: NW];
  end

  always_comb begin
    case (op_i)
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      OP_PASS: res_o = b_i;
      OP_SWAP: res_o = swapped;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/bcd_alu_adjust.sv
module bcd_alu_adjust
  import bcd_alu_pkg::*;
#(
  parameter int DW = 8,
  parameter int NW = 4
) (
  input  logic [DW-1:0] a_i,
  input  logic          c_i,
  input  logic          h_i,
  input  logic [3:0]    op_i,
  output logic [DW-1:0] res_o,
  output logic          c_o,
  output logic          h_o
);
  localparam logic [NW-1:0] NINE  = NW'(9);
  localparam logic [NW-1:0] SIX   = NW'(6);
  localparam logic [DW:0]   LO6   = (DW+1)'(6);
  localparam logic [DW-1:0] HI6   = DW'(6) << NW;

  logic          lo_fix;
  logic          hi_fix;
  logic [DW:0]   t;
  logic [NW-1:0] dig;

  assign lo_fix = (a_i[NW-1:0] > NINE) || h_i;
  assign t      = {1'b0, a_i} + (lo_fix ? LO6 : '0);
  assign hi_fix = (t[DW-1:NW] > (DW-NW)'(9)) || c_i || t[DW];

  always_comb begin
    res_o = '0;
    c_o   = 1'b0;
    h_o   = 1'b0;
    dig   = a_i[NW-1:0];
    case (op_i)
      OP_DPK: begin
        res_o = t[DW-1:0] + (hi_fix ? HI6 : '0);
        c_o   = hi_fix;
        h_o   = lo_fix;
      end
      OP_DUA: begin
        if (lo_fix) dig = a_i[NW-1:0] + SIX;
        res_o = {{(DW-NW){1'b0}}, dig};
        c_o   = lo_fix;
        h_o   = lo_fix;
      end
      OP_DUS: begin
        if (lo_fix) dig = a_i[NW-1:0] - SIX;
        res_o = {{(DW-NW){1'b0}}, dig};
        c_o   = lo_fix;
        h_o   = lo_fix;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bcd_alu.sv
module bcd_alu
  import bcd_alu_pkg::*;
#(
  parameter int DW = 8,
  parameter int NW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [3:0]    op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          c_i,
  input  logic          h_i,
  output logic [DW-1:0] res_o,
  output logic          c_o,
  output logic          h_o,
  output logic          z_o
);
  localparam logic [DW-1:0] ONE = DW'(1);

  logic [DW-1:0] ar_b, ar_sum, lg_res, ad_res, res_d;
  logic          ar_cin, ar_sub, ar_c, ar_h, ad_c, ad_h, c_d, h_d;

  always_comb begin
    ar_b   = b_i;
    ar_cin = 1'b0;
    ar_sub = 1'b0;
    case (op_i)
      OP_ADC: ar_cin = c_i;
      OP_SUB: ar_sub = 1'b1;
      OP_SBC: begin ar_sub = 1'b1; ar_cin = c_i; end
      OP_INC: ar_b = ONE;
      OP_DEC: begin ar_b = ONE; ar_sub = 1'b1; end
      default: ;
    endcase
  end

  bcd_alu_arith #(.DW(DW), .HB(NW)) u_arith (
    .a_i(a_i), .b_i(ar_b), .cin_i(ar_cin), .sub_i(ar_sub),
    .sum_o(ar_sum), .c_o(ar_c), .h_o(ar_h)
  );

  bcd_alu_logic #(.DW(DW), .NW(NW)) u_logic (
    .a_i(a_i), .b_i(b_i), .op_i(op_i), .res_o(lg_res)
  );

  bcd_alu_adjust #(.DW(DW), .NW(NW)) u_adjust (
    .a_i(a_i), .c_i(c_i), .h_i(h_i), .op_i(op_i),
    .res_o(ad_res), .c_o(ad_c), .h_o(ad_h)
  );

  always_comb begin
    case (op_i)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_INC, OP_DEC: begin
        res_d = ar_sum; c_d = ar_c; h_d = ar_h;
      end
      OP_AND, OP_OR, OP_XOR, OP_PASS, OP_SWAP: begin
        res_d = lg_res; c_d = 1'b0; h_d = 1'b0;
      end
      OP_DPK, OP_DUA, OP_DUS: begin
        res_d = ad_res; c_d = ad_c; h_d = ad_h;
      end
      default: begin
        res_d = '0; c_d = 1'b0; h_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o <= '0;
      c_o   <= 1'b0;
      h_o   <= 1'b0;
      z_o   <= 1'b1;
    end else begin
      res_o <= res_d;
      c_o   <= c_d;
      h_o   <= h_d;
      z_o   <= (res_d == '0);
    end
  end

  // R3
  add_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_ADD |=> {c_o, res_o} == ({1'b0, $past(a_i)} + {1'b0, $past(b_i)}));

  // R6
  logic_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i inside {OP_AND, OP_OR, OP_XOR, OP_PASS}) |=> !c_o && !h_o);

  // R7
  swap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_SWAP |=> res_o == {$past(a_i[NW-1:0]), $past(a_i[DW-1:NW])} && !c_o && !h_o);

  // R8
  dpk_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_DPK && c_i) |=> c_o);

  // R9
  dua_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_DUA |=> res_o[DW-1:NW] == '0 && c_o == h_o);

  // R10
  dus_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_DUS |=> res_o[DW-1:NW] == '0 && c_o == h_o);

  // R12
  unused_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i > OP_DUS |=> res_o == '0 && z_o && !c_o && !h_o);
endmodule

// File: tb/bcd_alu_tb_top.sv
module bcd_alu_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] op_i = '0;
  logic [7:0] a_i = '0, b_i = '0;
  logic       c_i = 1'b0, h_i = 1'b0;
  logic [7:0] res_o;
  logic       c_o, h_o, z_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [7:0] e_res = '0;
  logic       e_c = 0, e_h = 0, e_z = 1;
  string      e_req = "R1";
  logic [31:0] lfsr = 32'h1234_5678;

  always #5 clk_i = ~clk_i;

  bcd_alu dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .a_i(a_i), .b_i(b_i),
    .c_i(c_i), .h_i(h_i), .res_o(res_o), .c_o(c_o), .h_o(h_o), .z_o(z_o)
  );

  function automatic string req_of(int op);
    case (op)
      0, 1:       return "R3";
      2, 3:       return "R4";
      8, 9:       return "R5";
      4, 5, 6, 7: return "R6";
      10:         return "R7";
      11:         return "R8";
      12:         return "R9";
      13:         return "R10";
      default:    return "R12";
    endcase
  endfunction

  // behavioural model: returns {c,h,res}
  function automatic logic [9:0] model(int op, int a, int b, int ci, int hi);
    int r = 0, c = 0, h = 0, t, lf, uf;
    case (op)
      0, 1: begin
        t = a + b + (op == 1 ? ci : 0);
        c = (t > 255); h = ((a % 16) + (b % 16) + (op == 1 ? ci : 0)) > 15; r = t % 256;
      end
      2, 3: begin
        t = a - b - (op == 3 ? ci : 0);
        c = (t < 0); h = ((a % 16) - (b % 16) - (op == 3 ? ci : 0)) < 0; r = (t + 512) % 256;
      end
      4: r = a & b;
      5: r = a | b;
      6: r = a ^ b;
      7: r = b;
      8: begin t = a + 1; c = (t > 255); h = ((a % 16) + 1) > 15; r = t % 256; end
      9: begin t = a - 1; c = (t < 0); h = (a % 16) == 0; r = (t + 256) % 256; end
      10: r = (a % 16) * 16 + a / 16;
      11: begin
        lf = ((a % 16) > 9) || (hi != 0);
        t = a + (lf ? 6 : 0);
        uf = (((t % 256) / 16) > 9) || (ci != 0) || (t > 255);
        r = ((t % 256) + (uf ? 96 : 0)) % 256; c = uf; h = lf;
      end
      12, 13: begin
        lf = ((a % 16) > 9) || (hi != 0);
        if (!lf) r = a % 16;
        else if (op == 12) r = ((a % 16) + 6) % 16;
        else r = ((a % 16) + 10) % 16;
        c = lf; h = lf;
      end
      default: ;
    endcase
    return {c[0], h[0], r[7:0]};
  endfunction

  task automatic chk(string req, string what, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, got, exp);
    end
  endtask

  task automatic check_out(string req);
    chk(req, "res", res_o, e_res);
    chk(req, "carry", c_o, e_c);
    chk(req, "half", h_o, e_h);
    chk("R11", "zero", z_o, e_z);
  endtask

  // drive at negedge, confirm outputs hold (R2), then check after the edge
  task automatic apply(int op, int a, int b, int ci, int hi);
    logic [9:0] m;
    op_i = op[3:0]; a_i = a[7:0]; b_i = b[7:0]; c_i = ci[0]; h_i = hi[0];
    #1;
    check_out("R2");
    m = model(op, a, b, ci, hi);
    @(negedge clk_i);
    e_res = m[7:0]; e_c = m[9]; e_h = m[8]; e_z = (m[7:0] == 0);
    e_req = req_of(op);
    check_out(e_req);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] rv;
    a_i = 8'h5A; b_i = 8'hC3; op_i = 4'd0;
    repeat (3) @(negedge clk_i);
    check_out("R1");
    rst_ni = 1'b1;
    @(negedge clk_i);
    e_res = 8'h1D; e_c = 1; e_h = 0; e_z = 0; // 0x5A+0xC3 sampled on first edge, R3
    check_out("R3");

    // R3 carries and half-carries
    apply(0, 8'h0F, 8'h01, 0, 0);
    apply(0, 8'hFF, 8'h01, 0, 0);
    apply(1, 8'h7F, 8'h80, 1, 0);
    apply(1, 8'h08, 8'h07, 1, 0);
    // R4 borrows
    apply(2, 8'h10, 8'h01, 0, 0);
    apply(2, 8'h00, 8'h01, 0, 0);
    apply(3, 8'h55, 8'h55, 1, 0);
    apply(3, 8'h55, 8'h55, 0, 0);
    // R5
    apply(8, 8'hFF, 0, 0, 0);
    apply(8, 8'h0F, 0, 1, 1);
    apply(9, 8'h00, 0, 0, 0);
    apply(9, 8'h10, 0, 0, 0);
    // R6, R7
    apply(4, 8'hF0, 8'h3C, 1, 1);
    apply(5, 8'h00, 8'h00, 1, 1);
    apply(6, 8'hA5, 8'hA5, 0, 0);
    apply(7, 8'h12, 8'h9E, 1, 1);
    apply(10, 8'h3C, 0, 1, 1);
    // R8 packed correction corners
    apply(11, 8'h3C, 0, 0, 0);
    apply(11, 8'h9A, 0, 0, 0);
    apply(11, 8'h32, 0, 1, 1);
    apply(11, 8'hFA, 0, 0, 0);
    apply(11, 8'h45, 0, 0, 0);
    apply(11, 8'hA0, 0, 0, 0);
    // R9, R10 unpacked corrections
    apply(12, 8'h3B, 0, 0, 0);
    apply(12, 8'h77, 0, 0, 1);
    apply(12, 8'h94, 0, 1, 0);
    apply(13, 8'h4F, 0, 0, 0);
    apply(13, 8'h03, 0, 0, 1);
    apply(13, 8'h86, 0, 0, 0);
    // R12 unused codes
    apply(14, 8'hFF, 8'hFF, 1, 1);
    apply(15, 8'h81, 8'h18, 1, 1);

    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      rv = lfsr * 32'd2654435761;
      apply(int'(rv[3:0]), int'(rv[11:4]), int'(rv[19:12]), int'(rv[20]), int'(rv[21]));
    end
    finish_run();
  end
endmodule